// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block turns a small bank of pointer register sets into data-memory addresses. Each set holds four values: a current index, a signed step (modify), a buffer length and a buffer base. On an access request the selected set yields one address, and the set's index may be advanced. In pre-step mode the address is index plus step and the index does not change. In post-step mode the address is the current index and the index then advances by the step. In reversed mode the address is the current index with its low bits in reverse order, and the index then advances as in post-step mode. Reversed order suits transform reordering.

A non-zero length makes the advance circular. The advanced index folds back into the window [base, base+length), and that window may start at any address. A zero length makes the advance plain modular addition. Two full banks of sets exist, a primary and a secondary one. A bank select input chooses which bank is live, and the choice is registered, so it applies from the next cycle.

Top module: `circ_addr_gen`

## Requirements
- R1: While rst_n is low at a clock edge, every index, modify, length and base register in both banks becomes 0, the primary bank becomes active, and addr_out and addr_vld become 0.
- R2: With wr_en high, wr_data is written into set wr_sel of the active bank at the clock edge. The target field follows wr_field: 0 index, 1 modify, 2 length, 3 base. An access one cycle later sees the new value.
- R3: addr_out and addr_vld are registered. addr_vld is 1 in the cycle after a cycle with acc_en high and 0 otherwise, and addr_out carries the address of that access.
- R4: With acc_mode 0 (post-step; code 3 behaves the same), addr_out is the set's current index, and the index is replaced by its advanced value.
- R5: With acc_mode 1 (pre-step), addr_out is (index + modify) mod 2^AW, and the stored index keeps its value.
- R6: With a length of 0, the advanced index is (index + modify) mod 2^AW.
- R7: With a non-zero length L, let s = index + modify. If s >= base + L, the advanced index is s - L. If s < base, it is s + L. Otherwise it is s. The base needs no alignment.
- R8: modify is read as an AW-bit two's-complement number, so steps can be negative.
- R9: With acc_mode 2 (reversed), addr_out is the current index with bits [BRW-1:0] reversed (bit i goes to bit BRW-1-i) and its upper bits unchanged, and the index advances as in R4.
- R10: bank_sel (0 primary, 1 secondary) is registered. Accesses and writes use the bank selected in the previous cycle, and the two banks hold their values independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_sel | input | 1 | Requested bank, 0 primary, 1 secondary |
| wr_en | input | 1 | Register write strobe |
| wr_field | input | 2 | Field to write: 0 index, 1 modify, 2 length, 3 base |
| wr_sel | input | SW | Set written |
| wr_data | input | AW | Write value |
| acc_en | input | 1 | Address request |
| acc_mode | input | 2 | 0 post-step, 1 pre-step, 2 reversed, 3 post-step |
| acc_sel | input | SW | Set used by the request |
| addr_out | output | AW | Generated address |
| addr_vld | output | 1 | addr_out belongs to the previous cycle's request |

## Verification
The fold-back check assumes the index already lies inside its window, the step magnitude does not exceed the length, and base + length stays within the extended range. Under those inputs a single subtraction or addition of the length always lands back inside the window. The check that the stored index survives a pre-step request assumes no write to that index and no bank change in between. The stimulus loads each window with its index already inside it, and it keeps every step no larger than its length. It changes banks only in the directed bank tests, where those checks compare the bank each access actually used.

// File: rtl/cag_pkg.sv
// Shared encodings for the circular address generator.
package cag_pkg;
    typedef enum logic [1:0] {
        FLD_IDX  = 2'd0,
        FLD_MOD  = 2'd1,
        FLD_LEN  = 2'd2,
        FLD_BASE = 2'd3
    } fld_e;

    typedef enum logic [1:0] {
        AM_POST  = 2'd0,
        AM_PRE   = 2'd1,
        AM_BREV  = 2'd2,
        AM_POST3 = 2'd3
    } amode_e;
endpackage

// File: rtl/cag_regfile.sv
// Two banks of pointer register sets (index, modify, length, base).
// The active bank is a registered copy of bank_sel. One read port is
// addressed by rd_sel. The index write-back port targets the same set.
// When both touch the same index, a register write beats the write-back.
// Assumes rd_sel is stable for the whole cycle.
module cag_regfile
    import cag_pkg::*;
#(
    parameter int AW    = 16,
    parameter int NSETS = 16,
    localparam int SW   = $clog2(NSETS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bank_sel,
    input  logic          wr_en,
    input  logic [1:0]    wr_field,
    input  logic [SW-1:0] wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic [SW-1:0] rd_sel,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_data,
    output logic          bank_q,
    output logic [AW-1:0] rd_idx,
    output logic [AW-1:0] rd_mod,
    output logic [AW-1:0] rd_len,
    output logic [AW-1:0] rd_base
);
    logic [AW-1:0] idx_q  [2][NSETS];
    logic [AW-1:0] mod_q  [2][NSETS];
    logic [AW-1:0] len_q  [2][NSETS];
    logic [AW-1:0] base_q [2][NSETS];

    // Storage update: reset clear, bank latch, index write-back, then register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= 1'b0;
            for (int b = 0; b < 2; b++) begin
                for (int s = 0; s < NSETS; s++) begin
                    idx_q[b][s]  <= '0;
                    mod_q[b][s]  <= '0;
                    len_q[b][s]  <= '0;
                    base_q[b][s] <= '0;
                end
            end
        end else begin
            bank_q <= bank_sel;
            if (wb_en) idx_q[bank_q][rd_sel] <= wb_data;
            if (wr_en) begin
                case (wr_field)
                    FLD_IDX:  idx_q[bank_q][wr_sel]  <= wr_data;
                    FLD_MOD:  mod_q[bank_q][wr_sel]  <= wr_data;
                    FLD_LEN:  len_q[bank_q][wr_sel]  <= wr_data;
                    default:  base_q[bank_q][wr_sel] <= wr_data;
                endcase
            end
        end
    end

    // Read port of the active bank.
    always_comb begin
        rd_idx  = idx_q[bank_q][rd_sel];
        rd_mod  = mod_q[bank_q][rd_sel];
        rd_len  = len_q[bank_q][rd_sel];
        rd_base = base_q[bank_q][rd_sel];
    end

    AST_BANK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> bank_q == $past(bank_sel)); // R10
endmodule

// File: rtl/cag_step.sv
// Index arithmetic. Works out the pre-step address (plain sum) and the
// advanced index: linear when the length is 0, otherwise folded once
// into [base, base+len). Assumes |modify| <= len for the fold to land
// inside the window.
module cag_step #(
    parameter int AW = 16,
    localparam int EW = AW + 2
) (
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] mod,
    input  logic [AW-1:0] len,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] pre_addr,
    output logic [AW-1:0] nxt_idx
);
    logic signed [EW-1:0] s_idx, s_mod, s_len, s_base, s_lim, s_sum, s_fold, s_abs;

    // Extended signed arithmetic for the wrap comparison.
    always_comb begin
        s_idx  = signed'({2'b00, idx});
        s_mod  = signed'({{2{mod[AW-1]}}, mod});
        s_len  = signed'({2'b00, len});
        s_base = signed'({2'b00, base});
        s_lim  = s_base + s_len;
        s_sum  = s_idx + s_mod;
        s_abs  = (s_mod < 0) ? -s_mod : s_mod;
        if (s_sum >= s_lim)      s_fold = s_sum - s_len;
        else if (s_sum < s_base) s_fold = s_sum + s_len;
        else                     s_fold = s_sum;
        pre_addr = idx + mod;
        nxt_idx  = (len == '0) ? s_sum[AW-1:0] : s_fold[AW-1:0];
    end

    // Fold lands inside the window whenever the inputs respect the limits.
    always_comb begin
        if (len != '0 && s_idx >= s_base && s_idx < s_lim && s_abs <= s_len)
            AST_WRAP_INSIDE: assert (s_fold >= s_base && s_fold < s_lim); // R7
    end
endmodule

// File: rtl/cag_brev.sv
// Reverses the low BRW bits of an address and passes the upper bits through.
module cag_brev #(
    parameter int AW  = 16,
    parameter int BRW = 8
) (
    input  logic [AW-1:0] din,
    output logic [AW-1:0] dout
);
    genvar i;
    generate
        for (i = 0; i < BRW; i++) begin : g_rev
            assign dout[i] = din[BRW-1-i];
        end
        if (BRW < AW) begin : g_upper
            assign dout[AW-1:BRW] = din[AW-1:BRW];
        end
    endgenerate
endmodule

// File: rtl/circ_addr_gen.sv
// Circular buffer address generator top. A request reads one register
// set of the active bank. The address is registered, and the index is
// written back in the same edge for post-step and reversed modes.
// Assumes AW >= BRW.
module circ_addr_gen
    import cag_pkg::*;
#(
    parameter int AW    = 16,
    parameter int NSETS = 16,
    parameter int BRW   = 8,
    localparam int SW   = $clog2(NSETS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bank_sel,
    input  logic          wr_en,
    input  logic [1:0]    wr_field,
    input  logic [SW-1:0] wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          acc_en,
    input  logic [1:0]    acc_mode,
    input  logic [SW-1:0] acc_sel,
    output logic [AW-1:0] addr_out,
    output logic          addr_vld
);
    logic          bank_q, wb_en;
    logic [AW-1:0] rd_idx, rd_mod, rd_len, rd_base;
    logic [AW-1:0] pre_addr, nxt_idx, rev_addr;

    assign wb_en = acc_en && (acc_mode != AM_PRE);

    cag_regfile #(.AW(AW), .NSETS(NSETS)) u_regs (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
        .wr_en(wr_en), .wr_field(wr_field), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(acc_sel), .wb_en(wb_en), .wb_data(nxt_idx),
        .bank_q(bank_q), .rd_idx(rd_idx), .rd_mod(rd_mod),
        .rd_len(rd_len), .rd_base(rd_base)
    );

    cag_step #(.AW(AW)) u_step (
        .idx(rd_idx), .mod(rd_mod), .len(rd_len), .base(rd_base),
        .pre_addr(pre_addr), .nxt_idx(nxt_idx)
    );

    cag_brev #(.AW(AW), .BRW(BRW)) u_brev (
        .din(rd_idx), .dout(rev_addr)
    );

    // Output register: choose the address for the requested mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_out <= '0;
            addr_vld <= 1'b0;
        end else begin
            addr_vld <= acc_en;
            if (acc_en) begin
                case (acc_mode)
                    AM_PRE:  addr_out <= pre_addr;
                    AM_BREV: addr_out <= rev_addr;
                    default: addr_out <= rd_idx;
                endcase
            end
        end
    end

    // Checker state: remembers a pre-step request and the index it saw.
    logic          chk_pre_q, chk_bank_q;
    logic [SW-1:0] chk_sel_q;
    logic [AW-1:0] chk_idx_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_pre_q  <= 1'b0;
            chk_bank_q <= 1'b0;
            chk_sel_q  <= '0;
            chk_idx_q  <= '0;
        end else begin
            chk_pre_q  <= acc_en && acc_mode == AM_PRE &&
                          !(wr_en && wr_field == FLD_IDX && wr_sel == acc_sel);
            chk_bank_q <= bank_q;
            chk_sel_q  <= acc_sel;
            chk_idx_q  <= rd_idx;
        end
    end

    AST_PRE_KEEPS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        chk_pre_q && acc_sel == chk_sel_q && bank_q == chk_bank_q |-> rd_idx == chk_idx_q); // R5
    AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> addr_vld); // R3
    AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> !addr_vld); // R3
    AST_POST_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && acc_mode == AM_POST |=> addr_out == $past(rd_idx)); // R4
endmodule

// File: tb/sim_circ_addr_gen.sv
`timescale 1ns/1ps
module sim_circ_addr_gen;
    localparam int AW = 16, NSETS = 16, BRW = 8, SW = 4;
    localparam int NV = 28;
    // entry = {is_access, field_or_mode[1:0], sel[3:0], data_or_expected[15:0]}
    localparam logic [22:0] TBL [NV] = '{
        {1'b0, 2'd3, 4'd0, 16'd100},   // R2 base s0 (unaligned)
        {1'b0, 2'd2, 4'd0, 16'd10},    // R2 length s0
        {1'b0, 2'd1, 4'd0, 16'd3},     // R2 modify s0
        {1'b0, 2'd0, 4'd0, 16'd105},   // R2 index s0
        {1'b1, 2'd0, 4'd0, 16'd105},   // R4 post
        {1'b1, 2'd0, 4'd0, 16'd108},   // R4
        {1'b1, 2'd0, 4'd0, 16'd101},   // R7 fold from 111
        {1'b1, 2'd1, 4'd0, 16'd107},   // R5 pre 104+3
        {1'b1, 2'd0, 4'd0, 16'd104},   // R5 index kept
        {1'b1, 2'd3, 4'd0, 16'd107},   // R4 code 3 as post
        {1'b1, 2'd0, 4'd0, 16'd100},   // R7 exact end 110 -> 100
        {1'b0, 2'd3, 4'd1, 16'd100},   // base s1
        {1'b0, 2'd2, 4'd1, 16'd10},    // length s1
        {1'b0, 2'd1, 4'd1, 16'hFFFC},  // R8 modify -4
        {1'b0, 2'd0, 4'd1, 16'd102},
        {1'b1, 2'd0, 4'd1, 16'd102},   // R8
        {1'b1, 2'd0, 4'd1, 16'd108},   // R7 R8 fold below base 98 -> 108
        {1'b0, 2'd1, 4'd2, 16'd3},
        {1'b0, 2'd0, 4'd2, 16'hFFFE},
        {1'b1, 2'd0, 4'd2, 16'hFFFE},  // R6
        {1'b1, 2'd0, 4'd2, 16'h0001},  // R6 linear wrap mod 2^16
        {1'b0, 2'd1, 4'd3, 16'd1},
        {1'b0, 2'd0, 4'd3, 16'h1201},
        {1'b1, 2'd2, 4'd3, 16'h1280},  // R9 low 8 bits reversed
        {1'b1, 2'd2, 4'd3, 16'h1240},  // R9 index advanced
        {1'b1, 2'd0, 4'd3, 16'h1203},  // R9 advance then plain post
        {1'b1, 2'd1, 4'd1, 16'd100},   // R5 pre on s1: 104-4
        {1'b1, 2'd0, 4'd1, 16'd104}    // R5 s1 index kept
    };

    logic          clk = 1'b0, rst_n = 1'b0, bank_sel = 1'b0;
    logic          wr_en = 1'b0, acc_en = 1'b0;
    logic [1:0]    wr_field = '0, acc_mode = '0;
    logic [SW-1:0] wr_sel = '0, acc_sel = '0;
    logic [AW-1:0] wr_data = '0;
    logic [AW-1:0] addr_out;
    logic          addr_vld;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    circ_addr_gen #(.AW(AW), .NSETS(NSETS), .BRW(BRW)) u0 (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
        .wr_en(wr_en), .wr_field(wr_field), .wr_sel(wr_sel), .wr_data(wr_data),
        .acc_en(acc_en), .acc_mode(acc_mode), .acc_sel(acc_sel),
        .addr_out(addr_out), .addr_vld(addr_vld)
    );

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] f, input logic [SW-1:0] s, input logic [AW-1:0] d);
        wr_en = 1'b1; wr_field = f; wr_sel = s; wr_data = d;
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic acc(input logic [1:0] m, input logic [SW-1:0] s);
        acc_en = 1'b1; acc_mode = m; acc_sel = s;
        @(posedge clk); #1 acc_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1 addr_out after reset", addr_out, '0);
        check("R1 addr_vld after reset", {15'd0, addr_vld}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            if (!TBL[i][22]) begin
                wr(TBL[i][21:20], TBL[i][19:16], TBL[i][15:0]);
            end else begin
                acc(TBL[i][21:20], TBL[i][19:16]);
                case (TBL[i][21:20])
                    2'd1:    check("R5 table", addr_out, TBL[i][15:0]);
                    2'd2:    check("R9 table", addr_out, TBL[i][15:0]);
                    default: check("R4 R7 table", addr_out, TBL[i][15:0]);
                endcase
            end
        end

        // R3: valid after a request, low after an idle cycle
        acc(2'd1, 4'd2);
        check("R3 vld after request", {15'd0, addr_vld}, 16'd1);
        @(posedge clk); #1;
        check("R3 vld idle", {15'd0, addr_vld}, 16'd0);

        // R10: bank change applies from the next cycle
        bank_sel = 1'b1;
        acc(2'd0, 4'd0);
        check("R10 same-cycle uses primary", addr_out, 16'd103);
        acc(2'd0, 4'd0);
        check("R10 secondary empty", addr_out, 16'd0);
        wr(2'd0, 4'd0, 16'd500);
        acc(2'd0, 4'd0);
        check("R10 R2 secondary write", addr_out, 16'd500);
        bank_sel = 1'b0;
        acc(2'd0, 4'd0);
        check("R10 still secondary", addr_out, 16'd500);
        acc(2'd0, 4'd0);
        check("R10 primary kept", addr_out, 16'd106);

        // R1: reset clears the register sets
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        acc(2'd0, 4'd1);
        check("R1 registers cleared", addr_out, 16'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule